// File: doc/BRIEF.md
# Two-Layer Overlay Compositor

This block builds one display pixel from two stacked image layers. A display timing generator presents each active pixel with its X/Y coordinate. In the same cycle the upstream fetch logic presents the raw pixel words of both layers at that coordinate. The block decides which layer covers the coordinate and expands that layer's pixel to 24-bit RGB. It outputs the result one clock later. The top layer is always drawn over the base layer. Where neither layer covers the coordinate, a programmable background colour is output.

Each layer has its own rectangle (position and size in pixels), its own enable and its own pixel format. The formats are 16-bit RGB565, 15-bit RGB555 in a 16-bit word, and 32-bit XRGB. The base layer can take its pixels from an external video stream instead of its memory stream; that stream already carries 24-bit RGB. An overlay-mode enable switches rectangle handling on. With overlay mode off, the base layer alone fills the whole raster. All layer settings are shadowed and take effect at the next frame-start pulse. The background colour is not shadowed and applies at once.

Top module: `ovl_compositor`

## Requirements
- R1: During and right after reset, outValid is 0 and outRgb is 0.
- R2: outValid is pixValid delayed by exactly one clock, and every accepted coordinate yields one output pixel. outRgb is 0 whenever outValid is 0.
- R3: When overlay mode is on and a coordinate lies inside both enabled rectangles, the top layer's pixel is output.
- R4: A layer covers X when posX <= X < posX+width, and covers Y when posY <= Y < posY+height. The last covered column and row are included, and the first column and row past the rectangle are excluded. A width or height of 0 covers nothing.
- R5: A layer whose enable is 0 covers nothing, and the next layer down or the background shows through.
- R6: With overlay mode on, a coordinate that no enabled layer covers outputs bgColor.
- R7: With overlay mode off, every active coordinate outputs the base layer's pixel. The base rectangle and enable are ignored, and the top layer never shows.
- R8: Format code 2'b00 is RGB565 (red in bits 15:11, green in 10:5, blue in 4:0). Each component is widened to 8 bits by repeating its top bits below it.
- R9: Format code 2'b01 is RGB555 (red in bits 14:10, green in 9:5, blue in 4:0), widened the same way. Bit 15 has no effect.
- R10: Format codes 2'b10 and 2'b11 are XRGB: outRgb takes bits 23:0 of the word, and bits 31:24 have no effect.
- R11: With baseFromExt set, the base layer's pixel is extPixel taken as-is, and basePixel and baseFormat have no effect.
- R12: The layer settings are sampled only in a cycle with frameStart high. This covers overlay mode, enables, positions, sizes, formats and base source. A change made without a frameStart pulse leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Start-of-frame pulse; loads the layer settings |
| pixValid | input | 1 | Active-pixel strobe from the timing generator |
| pixX | input | XW | Current pixel column |
| pixY | input | YW | Current pixel row |
| ovlEnable | input | 1 | Overlay mode enable |
| topEnable | input | 1 | Top layer enable |
| topPosX | input | XW | Top layer left column |
| topPosY | input | YW | Top layer first row |
| topWidth | input | XW | Top layer width in pixels |
| topHeight | input | YW | Top layer height in pixels |
| topFormat | input | 2 | Top layer pixel format |
| baseEnable | input | 1 | Base layer enable |
| basePosX | input | XW | Base layer left column |
| basePosY | input | YW | Base layer first row |
| baseWidth | input | XW | Base layer width in pixels |
| baseHeight | input | YW | Base layer height in pixels |
| baseFormat | input | 2 | Base layer pixel format |
| baseFromExt | input | 1 | Take base layer pixels from the external stream |
| bgColor | input | 24 | Background colour, RGB888 |
| topPixel | input | 32 | Raw top layer pixel word |
| basePixel | input | 32 | Raw base layer pixel word from memory |
| extPixel | input | 24 | External stream pixel, RGB888 |
| outValid | output | 1 | Output pixel valid |
| outRgb | output | 24 | Composited RGB888 pixel |

## Verification
The hardest situation to reach is a settings change that must not take effect: new values sit on the ports while the shadowed ones still drive the raster. The stimulus moves and reformats the top layer without a frame-start pulse, sends pixels that the new settings would draw differently, then pulses frame start and sends the same coordinates again. Rectangle edges are probed one pixel inside and one pixel outside on each side, and a zero-width layer is placed over a covered area. The junk bits in the unused high pixel bits and in bit 15 of RGB555 are set so that any leak shows at the output.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int NL       = 2;  // number of layers
  localparam int TOP_IDX  = 0;  // drawn above
  localparam int BASE_IDX = 1;  // primary, drawn below
  localparam int FMT_W    = 2;
  localparam int FMT_WIDE = 1;  // format bit: 1 = 32-bit XRGB
  localparam int FMT_555  = 0;  // format bit within 16-bit: 1 = RGB555
  localparam int RGB_W    = 24;
  localparam int RAW_W    = 32;

  typedef struct packed {
    logic valid;
    logic pickTop;
    logic pickBase;
    logic baseExt;
  } ovl_strobe_t;

  function automatic logic [RGB_W-1:0] expandPix(input logic [FMT_W-1:0] fmt,
                                                 input logic [RAW_W-1:0] raw);
    logic [4:0] r5, g5, b5;
    logic [5:0] g6;
    if (fmt[FMT_WIDE]) begin
      return raw[23:0];
    end
    b5 = raw[4:0];
    if (fmt[FMT_555]) begin
      r5 = raw[14:10];
      g5 = raw[9:5];
      return {r5, r5[4:2], g5, g5[4:2], b5, b5[4:2]};
    end
    r5 = raw[15:11];
    g6 = raw[10:5];
    return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
  endfunction
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 11
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        frameStart,
  input  logic                        pixValid,
  input  logic [XW-1:0]               pixX,
  input  logic [YW-1:0]               pixY,
  input  logic                        ovlEnIn,
  input  logic [NL-1:0]               layerEnIn,
  input  logic [NL-1:0][XW-1:0]       posXIn,
  input  logic [NL-1:0][YW-1:0]       posYIn,
  input  logic [NL-1:0][XW-1:0]       widthIn,
  input  logic [NL-1:0][YW-1:0]       heightIn,
  input  logic [NL-1:0][FMT_W-1:0]    fmtIn,
  input  logic                        baseExtIn,
  output logic [NL-1:0][FMT_W-1:0]    fmtSh,
  output ovl_strobe_t                 strobe
);
  logic                  ovlEnSh;
  logic [NL-1:0]         enSh;
  logic [NL-1:0][XW-1:0] posXSh, widthSh;
  logic [NL-1:0][YW-1:0] posYSh, heightSh;
  logic                  baseExtSh;
  logic [NL-1:0]         hit;

  // Shadow registers: loaded only on the frame-start pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovlEnSh   <= 1'b0;
      enSh      <= '0;
      posXSh    <= '0;
      posYSh    <= '0;
      widthSh   <= '0;
      heightSh  <= '0;
      fmtSh     <= '0;
      baseExtSh <= 1'b0;
    end else if (frameStart) begin
      ovlEnSh   <= ovlEnIn;
      enSh      <= layerEnIn;
      posXSh    <= posXIn;
      posYSh    <= posYIn;
      widthSh   <= widthIn;
      heightSh  <= heightIn;
      fmtSh     <= fmtIn;
      baseExtSh <= baseExtIn;
    end
  end

  // Per-layer rectangle hit test, end bound exclusive
  for (genvar l = 0; l < NL; l++) begin : g_hit
    logic [XW:0] xEnd;
    logic [YW:0] yEnd;
    assign xEnd = {1'b0, posXSh[l]} + {1'b0, widthSh[l]};
    assign yEnd = {1'b0, posYSh[l]} + {1'b0, heightSh[l]};
    assign hit[l] = enSh[l]
                  && (pixX >= posXSh[l]) && ({1'b0, pixX} < xEnd)
                  && (pixY >= posYSh[l]) && ({1'b0, pixY} < yEnd);
  end

  // Fixed priority: top layer wins, base next, else background
  always_comb begin
    strobe.valid   = pixValid;
    strobe.baseExt = baseExtSh;
    if (ovlEnSh) begin
      strobe.pickTop  = hit[TOP_IDX];
      strobe.pickBase = !hit[TOP_IDX] && hit[BASE_IDX];
    end else begin
      strobe.pickTop  = 1'b0;
      strobe.pickBase = 1'b1;
    end
  end

  // R12: settings stay frozen between frame-start pulses
  assert_shadow_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(posXSh) && $stable(posYSh) && $stable(widthSh)
                    && $stable(heightSh) && $stable(fmtSh) && $stable(enSh)
                    && $stable(ovlEnSh) && $stable(baseExtSh));

  // R4: a chosen top pixel lies inside the top rectangle
  assert_top_inside_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pickTop |-> (pixX - posXSh[TOP_IDX]) < widthSh[TOP_IDX]
                       && (pixY - posYSh[TOP_IDX]) < heightSh[TOP_IDX]
                       && pixX >= posXSh[TOP_IDX] && pixY >= posYSh[TOP_IDX]);
endmodule

// File: rtl/ovl_datapath.sv
module ovl_datapath
  import ovl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ovl_strobe_t              strobe,
  input  logic [NL-1:0][FMT_W-1:0] fmtSh,
  input  logic [RAW_W-1:0]         topPix,
  input  logic [RAW_W-1:0]         baseDmaPix,
  input  logic [RGB_W-1:0]         extPix,
  input  logic [RGB_W-1:0]         bgColor,
  output logic                     outValid,
  output logic [RGB_W-1:0]         outRgb
);
  logic [NL-1:0][RAW_W-1:0] rawPix;
  logic [NL-1:0][RGB_W-1:0] expPix;
  logic [RGB_W-1:0]         baseRgb, nextRgb;

  assign rawPix[TOP_IDX]  = topPix;
  assign rawPix[BASE_IDX] = baseDmaPix;

  for (genvar l = 0; l < NL; l++) begin : g_expand
    assign expPix[l] = expandPix(fmtSh[l], rawPix[l]);
  end

  assign baseRgb = strobe.baseExt ? extPix : expPix[BASE_IDX];

  always_comb begin
    if (strobe.pickTop)       nextRgb = expPix[TOP_IDX];
    else if (strobe.pickBase) nextRgb = baseRgb;
    else                      nextRgb = bgColor;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRgb   <= '0;
    end else begin
      outValid <= strobe.valid;
      outRgb   <= strobe.valid ? nextRgb : '0;
    end
  end

  // R3: never more than one layer selected
  assert_one_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pickTop, strobe.pickBase}));

  // R2: one output per accepted coordinate, one cycle later
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid |=> outValid);

  // R2: idle cycles produce a blank, invalid output
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.valid |=> !outValid && outRgb == '0);

  // R6: uncovered pixels carry the background colour
  assert_background_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valid && !strobe.pickTop && !strobe.pickBase |=> outRgb == $past(bgColor));
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameStart,
  input  logic          pixValid,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  input  logic          ovlEnable,
  input  logic          topEnable,
  input  logic [XW-1:0] topPosX,
  input  logic [YW-1:0] topPosY,
  input  logic [XW-1:0] topWidth,
  input  logic [YW-1:0] topHeight,
  input  logic [1:0]    topFormat,
  input  logic          baseEnable,
  input  logic [XW-1:0] basePosX,
  input  logic [YW-1:0] basePosY,
  input  logic [XW-1:0] baseWidth,
  input  logic [YW-1:0] baseHeight,
  input  logic [1:0]    baseFormat,
  input  logic          baseFromExt,
  input  logic [23:0]   bgColor,
  input  logic [31:0]   topPixel,
  input  logic [31:0]   basePixel,
  input  logic [23:0]   extPixel,
  output logic          outValid,
  output logic [23:0]   outRgb
);
  ovl_strobe_t              strobe;
  logic [NL-1:0][FMT_W-1:0] fmtSh;

  ovl_ctrl #(.XW(XW), .YW(YW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .pixValid  (pixValid),
    .pixX      (pixX),
    .pixY      (pixY),
    .ovlEnIn   (ovlEnable),
    .layerEnIn ({baseEnable, topEnable}),
    .posXIn    ({basePosX, topPosX}),
    .posYIn    ({basePosY, topPosY}),
    .widthIn   ({baseWidth, topWidth}),
    .heightIn  ({baseHeight, topHeight}),
    .fmtIn     ({baseFormat, topFormat}),
    .baseExtIn (baseFromExt),
    .fmtSh     (fmtSh),
    .strobe    (strobe)
  );

  ovl_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fmtSh     (fmtSh),
    .topPix    (topPixel),
    .baseDmaPix(basePixel),
    .extPix    (extPixel),
    .bgColor   (bgColor),
    .outValid  (outValid),
    .outRgb    (outRgb)
  );
endmodule

// File: tb/ovl_compositor_test.sv
`timescale 1ns/1ps
module ovl_compositor_test;
  localparam int XW = 11;
  localparam int YW = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rstN, frameStart, pixValid;
  logic [XW-1:0] pixX;
  logic [YW-1:0] pixY;
  logic ovlEnable, topEnable, baseEnable, baseFromExt;
  logic [XW-1:0] topPosX, topWidth, basePosX, baseWidth;
  logic [YW-1:0] topPosY, topHeight, basePosY, baseHeight;
  logic [1:0] topFormat, baseFormat;
  logic [23:0] bgColor, extPixel;
  logic [31:0] topPixel, basePixel;
  logic outValid;
  logic [23:0] outRgb;

  ovl_compositor #(.XW(XW), .YW(YW)) uut (.*);

  int checks = 0;
  int fails  = 0;
  logic [23:0] expQ[$];
  string tagQ[$];

  // settings the design should currently be using
  bit aOvl, aTopEn, aBaseEn, aExt;
  int aTX, aTY, aTW, aTH, aBX, aBY, aBW, aBH;
  logic [1:0] aTF, aBF;

  function automatic logic [7:0] up5(int v);
    return 8'((v << 3) | (v >> 2));
  endfunction
  function automatic logic [7:0] up6(int v);
    return 8'((v << 2) | (v >> 4));
  endfunction

  function automatic logic [23:0] widen(logic [1:0] f, logic [31:0] p);
    if (f[1]) return p[23:0];
    if (f[0]) return {up5(int'(p[14:10])), up5(int'(p[9:5])), up5(int'(p[4:0]))};
    return {up5(int'(p[15:11])), up6(int'(p[10:5])), up5(int'(p[4:0]))};
  endfunction

  function automatic bit inside_rect(int px, int py, int w, int h, int x, int y);
    return (x >= px) && (x < px + w) && (y >= py) && (y < py + h);
  endfunction

  function automatic logic [23:0] model(int x, int y);
    logic [23:0] baseRgb;
    baseRgb = aExt ? extPixel : widen(aBF, basePixel);
    if (!aOvl) return baseRgb;
    if (aTopEn && inside_rect(aTX, aTY, aTW, aTH, x, y)) return widen(aTF, topPixel);
    if (aBaseEn && inside_rect(aBX, aBY, aBW, aBH, x, y)) return baseRgb;
    return bgColor;
  endfunction

  task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
    end
  endtask

  // driver: presents one coordinate and pushes its expected pixel
  task automatic sendPix(int x, int y, logic [31:0] tp, logic [31:0] bp,
                         logic [23:0] ep, string tag);
    @(negedge clk);
    pixValid = 1'b1;
    pixX = XW'(x);
    pixY = YW'(y);
    topPixel = tp;
    basePixel = bp;
    extPixel = ep;
    expQ.push_back(model(x, y));
    tagQ.push_back(tag);
  endtask

  task automatic frame();
    @(negedge clk);
    pixValid = 1'b0;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    aOvl = ovlEnable; aTopEn = topEnable; aBaseEn = baseEnable; aExt = baseFromExt;
    aTX = int'(topPosX); aTY = int'(topPosY); aTW = int'(topWidth); aTH = int'(topHeight);
    aBX = int'(basePosX); aBY = int'(basePosY); aBW = int'(baseWidth); aBH = int'(baseHeight);
    aTF = topFormat; aBF = baseFormat;
  endtask

  // R2: after idle cycles the output must be blank and invalid
  task automatic idleCheck();
    @(negedge clk);
    pixValid = 1'b0;
    repeat (2) @(negedge clk);
    check(!outValid && outRgb == 24'h0, "R2 idle output", outRgb, 24'h0);
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", outRgb, 24'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outRgb == e, t, outRgb, e);
      end
    end
  end

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%06h expected=%06h", 24'h0, 24'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  localparam logic [31:0] P565  = 32'hAB00_F81F;  // r=31 g=0 b=31, junk top byte
  localparam logic [31:0] P565B = 32'h0000_07E0;  // g=63
  localparam logic [31:0] P555  = 32'h0000_A9CA;  // bit15 set, r=10 g=14 b=10
  localparam logic [31:0] PX1   = 32'h5A12_3456;
  localparam logic [31:0] PX2   = 32'hFF65_4321;
  localparam logic [23:0] EXT   = 24'hC0FFEE;

  initial begin
    rstN = 1'b0; frameStart = 1'b0; pixValid = 1'b0; pixX = '0; pixY = '0;
    ovlEnable = 1'b0; topEnable = 1'b0; baseEnable = 1'b0; baseFromExt = 1'b0;
    topPosX = '0; topPosY = '0; topWidth = '0; topHeight = '0; topFormat = 2'b00;
    basePosX = '0; basePosY = '0; baseWidth = '0; baseHeight = '0; baseFormat = 2'b00;
    bgColor = 24'h123456; topPixel = '0; basePixel = '0; extPixel = '0;
    repeat (3) @(negedge clk);
    check(!outValid && outRgb == 24'h0, "R1 reset outputs", outRgb, 24'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && outRgb == 24'h0, "R1 after reset", outRgb, 24'h0);

    // overlay on, top 4x3 at (10,10) RGB565, base 20x20 at (0,0) XRGB
    ovlEnable = 1'b1;
    topEnable = 1'b1; topPosX = 10; topPosY = 10; topWidth = 4; topHeight = 3; topFormat = 2'b00;
    baseEnable = 1'b1; basePosX = 0; basePosY = 0; baseWidth = 20; baseHeight = 20; baseFormat = 2'b10;
    frame();
    sendPix(10, 10, P565, PX1, EXT, "R3 top over base");
    sendPix(11, 11, P565B, PX1, EXT, "R8 RGB565 widening");
    sendPix(9, 10, P565, PX1, EXT, "R4 column before top");
    sendPix(13, 10, P565, PX1, EXT, "R4 last top column");
    sendPix(14, 10, P565, PX2, EXT, "R4 column past top");
    sendPix(10, 12, P565, PX1, EXT, "R4 last top row");
    sendPix(10, 13, P565, PX1, EXT, "R4 row past top");
    sendPix(19, 19, P565, PX2, EXT, "R10 XRGB top byte ignored");
    sendPix(20, 5, P565, PX1, EXT, "R6 background right of base");
    sendPix(25, 25, P565, PX1, EXT, "R6 background outside all");
    idleCheck();

    // R5: disable top, then base
    topEnable = 1'b0;
    frame();
    sendPix(10, 10, P565, PX1, EXT, "R5 top disabled shows base");
    baseEnable = 1'b0;
    frame();
    sendPix(5, 5, P565, PX1, EXT, "R5 base disabled shows background");

    // R9: RGB555 top with bit15 set
    topEnable = 1'b1; topFormat = 2'b01; baseEnable = 1'b1;
    frame();
    sendPix(12, 11, P555, PX1, EXT, "R9 RGB555 widening");
    sendPix(12, 11, P555 & 32'h7FFF, PX1, EXT, "R9 bit15 no effect");

    // R4: zero width hides top
    topWidth = 0;
    frame();
    sendPix(10, 10, P565, PX2, EXT, "R4 zero width hides top");
    topWidth = 4;

    // R11: external source for base
    baseFromExt = 1'b1; baseFormat = 2'b00;
    frame();
    sendPix(2, 2, P565, PX1, EXT, "R11 base from external stream");
    sendPix(3, 2, P565, PX2, 24'h010203, "R11 memory pixel ignored");
    sendPix(11, 11, P555, PX1, EXT, "R3 top over external base");
    baseFromExt = 1'b0; baseFormat = 2'b10;

    // R7: overlay off, base everywhere even disabled, top hidden
    ovlEnable = 1'b0; baseEnable = 1'b0;
    frame();
    sendPix(11, 11, P565, PX1, EXT, "R7 top hidden when overlay off");
    sendPix(300, 200, P565, PX2, EXT, "R7 base fills raster");
    idleCheck();

    // R12: settings change without frame start has no effect
    ovlEnable = 1'b1; baseEnable = 1'b1; topFormat = 2'b00;
    frame();
    topPosX = 100; topFormat = 2'b10; ovlEnable = 1'b0;
    sendPix(10, 10, P565, PX1, EXT, "R12 old top position kept");
    sendPix(100, 10, P565, PX1, EXT, "R12 new position not yet live");
    frame();
    sendPix(10, 10, P565, PX1, EXT, "R12 new settings after frame start");
    ovlEnable = 1'b1;
    frame();
    sendPix(101, 11, P565, PX2, EXT, "R12 moved top now shown");
    sendPix(10, 10, P565, PX2, EXT, "R12 old spot now base");

    idleCheck();
    check(expQ.size() == 0, "R2 every pixel produced", 24'(expQ.size()), 24'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule